// File: doc/BRIEF.md
# Partitioned Carry-Select Adder

This block adds two unsigned operands and an incoming carry, giving a sum of the same width and a carry-out. The operand width is split into consecutive segments whose sizes come from a parameter list. The segment at the least significant end is a single ripple chain, because its carry is known from the start. Every segment above it computes two results in parallel, one that assumes an incoming carry of 0 and one that assumes 1. When the true carry arrives, a multiplexer picks the right sum bits and the right carry-out. The same source builds an even split, such as four segments of 4 bits, or a split that grows toward the top, such as 2, 2, 3, 4, 5. In the grown split, each segment's local carry settles at about the time the selected carry from below reaches it.

Each ripple chain is made of full-adder cells only. If the segment list does not add up to the operand width, elaboration stops. A thin wrapper puts registers on the operands and on the result, with a written-out load enable on the operand registers. Operands captured at one rising edge appear at the outputs after the next rising edge. The reset input is asynchronous and active low, and its release is synchronized inside the block.

Top module: `csel_adder`

## Requirements
- R1: After a capture, `sum_out` equals (`a_in` + `b_in` + `cin_in`) modulo 2^WIDTH, with the operands treated as unsigned.
- R2: `cout_out` equals bit WIDTH of the full-width total `a_in` + `b_in` + `cin_in`, which is the carry-out of the most significant segment.
- R3: With the variable split 2-2-3-4-5, least significant segment first, the block gives the same sum and carry-out as with the even 4-4-4-4 split, for every operand pattern.
- R4: A carry generated at any bit position reaches the top correctly across every segment boundary. Low-bit masks of all ones plus a carry produce exactly one set bit, 2^k, or a carry-out when k equals WIDTH.
- R5: When both operands are all ones and `cin_in` is 1, the sum is all ones and the carry-out is 1. When one operand is all ones, the other is 0 and `cin_in` is 1, the sum is 0 and the carry-out is 1.
- R6: While `rst_n` is low, `sum_out` and `cout_out` are 0, whatever `en` and the operands are doing.
- R7: While `en` is low, the operand registers keep their value, so `sum_out` and `cout_out` stay unchanged even when the operand inputs change.
- R8: Operands present with `en` high at rising edge n are visible at the outputs after rising edge n+1, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized on release |
| en | input | 1 | Load enable for the operand registers |
| a_in | input | WIDTH | First unsigned operand |
| b_in | input | WIDTH | Second unsigned operand |
| cin_in | input | 1 | Incoming carry |
| sum_out | output | WIDTH | Registered sum |
| cout_out | output | 1 | Registered carry-out |

## Verification
The clocked properties assume that `en` and the operand inputs are stable at each rising edge once the synchronized reset has been released. They also assume that `en` stays low during the two edges in which the reset synchronizer is still clearing. The stimulus changes every input only on the falling edge, and it keeps `en` low until the internal reset is free. Both split variants see the same operands. The stimulus includes carry chains ending at every bit position, the all-ones corners, and ten thousand pseudo-random pairs.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int FIELD_W  = 8;
  localparam int MAX_SEGS = 32;
  localparam int LIST_W   = FIELD_W * MAX_SEGS;

  typedef logic [LIST_W-1:0] seg_list_t;

  // size of segment idx; segment 0 is the least significant
  function automatic int seg_size(seg_list_t list, int idx);
    return int'(list[idx*FIELD_W +: FIELD_W]);
  endfunction

  // first bit position of segment idx
  function automatic int seg_base(seg_list_t list, int idx);
    int acc = 0;
    for (int k = 0; k < idx; k++) acc += seg_size(list, k);
    return acc;
  endfunction

  function automatic int seg_total(seg_list_t list, int nseg);
    return seg_base(list, nseg);
  endfunction
endpackage

// File: rtl/csel_fa.sv
module csel_fa (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  always_comb begin
    s  = x ^ y ^ ci;
    co = (x & y) | (x & ci) | (y & ci);
  end
endmodule

// File: rtl/csel_rca.sv
module csel_rca #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] chain;

  assign chain[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_cell
    csel_fa u_fa (
      .x  (x[i]),
      .y  (y[i]),
      .ci (chain[i]),
      .s  (s[i]),
      .co (chain[i+1])
    );
  end

  assign co = chain[W];
endmodule

// File: rtl/csel_seg.sv
module csel_seg #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W-1:0] s_lo, s_hi;
  logic         co_lo, co_hi;

  // candidate assuming no incoming carry
  csel_rca #(.W(W)) u_rca_lo (
    .x  (x),
    .y  (y),
    .ci (1'b0),
    .s  (s_lo),
    .co (co_lo)
  );

  // candidate assuming an incoming carry
  csel_rca #(.W(W)) u_rca_hi (
    .x  (x),
    .y  (y),
    .ci (1'b1),
    .s  (s_hi),
    .co (co_hi)
  );

  always_comb begin
    if (ci) begin
      s  = s_hi;
      co = co_hi;
    end else begin
      s  = s_lo;
      co = co_lo;
    end
  end
endmodule

// File: rtl/csel_core.sv
module csel_core #(
  parameter int                   WIDTH = 16,
  parameter int                   NSEG  = 4,
  parameter logic [NSEG*8-1:0]    SEG_W = {8'd4, 8'd4, 8'd4, 8'd4}
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  import csel_pkg::*;

  localparam seg_list_t LIST  = seg_list_t'(SEG_W);
  localparam int        TOTAL = seg_total(LIST, NSEG);

  if (TOTAL != WIDTH) begin : g_bad_split
    $error("csel_core: segment sizes add to %0d, width is %0d", TOTAL, WIDTH);
  end

  logic [NSEG:0] carry;
  assign carry[0] = cin;

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    localparam int BASE = seg_base(LIST, i);
    localparam int SZ   = seg_size(LIST, i);
    if (i == 0) begin : g_ripple
      csel_rca #(.W(SZ)) u_rca (
        .x  (a[BASE +: SZ]),
        .y  (b[BASE +: SZ]),
        .ci (carry[i]),
        .s  (sum[BASE +: SZ]),
        .co (carry[i+1])
      );
    end else begin : g_select
      csel_seg #(.W(SZ)) u_sel (
        .x  (a[BASE +: SZ]),
        .y  (b[BASE +: SZ]),
        .ci (carry[i]),
        .s  (sum[BASE +: SZ]),
        .co (carry[i+1])
      );
    end
  end

  assign cout = carry[NSEG];
endmodule

// File: rtl/csel_adder.sv
module csel_adder #(
  parameter int                WIDTH = 16,
  parameter int                NSEG  = 4,
  parameter logic [NSEG*8-1:0] SEG_W = {8'd4, 8'd4, 8'd4, 8'd4}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             cin_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             cout_out
);
  // reset release synchronizer
  logic [1:0] rst_pipe;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ok = rst_pipe[1];

  // operand stage
  logic [WIDTH-1:0] a_q, b_q, a_d, b_d;
  logic             c_q, c_d;

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    c_d = c_q;
    if (en) begin
      a_d = a_in;
      b_d = b_in;
      c_d = cin_in;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= 1'b0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
      c_q <= c_d;
    end
  end

  // adder core
  logic [WIDTH-1:0] sum_c;
  logic             cout_c;

  csel_core #(.WIDTH(WIDTH), .NSEG(NSEG), .SEG_W(SEG_W)) u_core (
    .a    (a_q),
    .b    (b_q),
    .cin  (c_q),
    .sum  (sum_c),
    .cout (cout_c)
  );

  // result stage
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      sum_out  <= '0;
      cout_out <= 1'b0;
    end else begin
      sum_out  <= sum_c;
      cout_out <= cout_c;
    end
  end

  // reference total of the held operands, for the properties only
  logic [WIDTH:0] ref_total;
  assign ref_total = {1'b0, a_q} + {1'b0, b_q} + {{WIDTH{1'b0}}, c_q};

  p_sum_r1: assert property (@(posedge clk) disable iff (!rst_ok)
    sum_out == $past(ref_total[WIDTH-1:0]))
    else $error("sum differs from reference total");

  p_cout_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    cout_out == $past(ref_total[WIDTH]))
    else $error("carry-out differs from reference total");

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    !en |=> ($stable(a_q) && $stable(b_q) && $stable(c_q)))
    else $error("operands changed while load enable was low");

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    en |=> (a_q == $past(a_in) && b_q == $past(b_in) && c_q == $past(cin_in)))
    else $error("operands not captured on enabled edge");
endmodule

// File: tb/sim_csel_adder.sv
`timescale 1ns/1ps
module sim_csel_adder;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n, en, cin;
  logic [W-1:0] a, b;
  logic [W-1:0] s0, s1;
  logic         c0, c1;

  always #2.5 clk = ~clk;

  csel_adder #(.WIDTH(W), .NSEG(4), .SEG_W({8'd4, 8'd4, 8'd4, 8'd4})) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .a_in(a), .b_in(b), .cin_in(cin),
    .sum_out(s0), .cout_out(c0)
  );

  csel_adder #(.WIDTH(W), .NSEG(5), .SEG_W({8'd5, 8'd4, 8'd3, 8'd2, 8'd2})) u1 (
    .clk(clk), .rst_n(rst_n), .en(en), .a_in(a), .b_in(b), .cin_in(cin),
    .sum_out(s1), .cout_out(c1)
  );

  typedef struct {
    logic [W:0] exp;
    string      tag;
  } item_t;

  item_t      q[$];
  int         checks = 0;
  int         errors = 0;
  bit         done   = 1'b0;
  logic [W:0] last_exp = '0;

  task automatic chk(string tag, logic [W:0] act, logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W:0] model(logic [W-1:0] x, logic [W-1:0] y, logic ci);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  endfunction

  task automatic drive(logic [W-1:0] x, logic [W-1:0] y, logic ci, string tag);
    item_t it;
    @(negedge clk);
    a = x; b = y; cin = ci; en = 1'b1;
    it.exp = model(x, y, ci);
    it.tag = tag;
    q.push_back(it);
    last_exp = it.exp;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      en = 1'b0;
    end
  endtask

  // monitor: result of an enabled edge is compared after the following edge
  initial begin
    bit pend = 1'b0;
    bit cap;
    item_t it;
    forever begin
      @(posedge clk);
      cap = en && rst_n;
      #1;
      if (pend) begin
        if (q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R8 actual=unexpected-result expected=empty");
        end else begin
          it = q.pop_front();
          chk(it.tag, {c0, s0}, it.exp);
          chk("R3", {c1, s1}, it.exp);
        end
      end
      pend = cap;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; a = '1; b = '1; cin = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6", {c0, s0}, '0);
    chk("R6", {c1, s1}, '0);
    en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6", {c0, s0}, '0);

    // R5 corners
    drive('1, '1, 1'b1, "R5");
    drive('1, '0, 1'b1, "R5");
    drive('1, 16'h0001, 1'b0, "R5");
    drive('0, '0, 1'b0, "R1");

    // R4 carry chains ending at every bit position
    for (int k = 0; k <= W; k++) begin
      logic [W-1:0] m;
      m = (k == W) ? '1 : W'((17'h1 << k) - 1);
      drive(m, '0, 1'b1, "R4");
      drive('0, m, 1'b1, "R4");
      drive(m, (k == W) ? '0 : W'(17'h1 << k) >> 0 & '0 | 16'h0001, 1'b0, "R4");
    end

    // R8 latency
    idle(3);
    begin
      logic [W:0] prev;
      prev = last_exp;
      drive(16'h1234, 16'h4321, 1'b1, "R8");
      @(negedge clk);
      en = 1'b0; a = 16'hffff;
      chk("R8", {c0, s0}, prev);
      @(negedge clk);
      chk("R8", {c0, s0}, model(16'h1234, 16'h4321, 1'b1));
    end

    // R7 hold with changing inputs
    idle(2);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      en = 1'b0; a = W'($urandom); b = W'($urandom); cin = 1'($urandom);
      chk("R7", {c0, s0}, last_exp);
      chk("R7", {c1, s1}, last_exp);
    end

    // R1 / R2 random traffic
    for (int i = 0; i < 10000; i++) begin
      drive(W'($urandom), W'($urandom), 1'($urandom), (i % 2 == 0) ? "R1" : "R2");
    end
    idle(4);
    chk("R8", W'(q.size()), '0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule